// File: doc/BRIEF.md
# 12-bit Free-Running Timer with Coherent Two-Byte Read

This block is a 12-bit up-counter that advances once on every clock cycle in which its tick input is high. The tick normally arrives once per microsecond, so the count covers about 4 ms before it wraps. Software reads the counter over an 8-bit data path in two steps, low byte first and then high byte. The low-byte read also captures the upper four count bits into a holding register, and the high-byte read returns that captured nibble. The two halves therefore always belong to the same count value, however long software waits between the reads.

The block also produces two periodic interrupt pulses. The fast pulse fires each time the count reaches a multiple of 128 ticks (128 µs). The slow pulse fires each time the count reaches a multiple of 1024 ticks (1.024 ms). Each pulse is one clock cycle wide. Masking and priority of these pulses are handled elsewhere.

The reset input is asynchronous and active low. Assertion takes effect at once. Release is synchronised inside the block and takes effect two clock edges after the input rises.

Top module: `tmr12_snapshot`

## Requirements
- R1: On a clock edge with `tick` high, the count rises by exactly one. On an edge with `tick` low, the count is unchanged.
- R2: When a tick arrives at count 0xFFF, the count becomes 0x000.
- R3: When `rd_lo` is high at a clock edge, `rdata` shows count bits 7:0 from the following cycle on. The value is the count as it stood before that edge, even if a tick arrives at the same edge.
- R4: When `rd_lo` is high at an edge, count bits 11:8 from before that edge are stored in the holding register. The holding register keeps this value until the next low-byte read.
- R5: When `rd_hi` is high at an edge and `rd_lo` is low, `rdata` becomes the holding register in bits 3:0 with zeros in bits 7:4. The result is unaffected by ticks since the last low-byte read.
- R6: `irq_fast` is high for exactly the one cycle after a tick edge that moves the count to a multiple of 128. It is low in all other cycles.
- R7: `irq_slow` is high for exactly the one cycle after a tick edge that moves the count to a multiple of 1024. It is low in all other cycles.
- R8: Reset clears the count, the holding register, `rdata` and both interrupt outputs. After reset, the first high-byte read returns 0x00.
- R9: When `rd_lo` and `rd_hi` are both high at the same edge, the low-byte read takes effect, including the nibble capture.
- R10: While both read strobes are low, `rdata` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Count enable, one cycle per microsecond |
| rd_lo | input | 1 | Low-byte read strobe; also captures the upper nibble |
| rd_hi | input | 1 | High-byte read strobe; returns the captured nibble |
| rdata | output | 8 | Read data, registered, held between reads |
| irq_fast | output | 1 | One-cycle pulse every 128 ticks |
| irq_slow | output | 1 | One-cycle pulse every 1024 ticks |

## Verification
The bench runs the count through more than one full wrap. It reads the low byte at ticking edges and reads the high byte several ticks later, so that a design returning the live upper bits, or the post-increment value, gives nibbles or low bytes that do not match. It reads across the 0xFFF to 0x000 boundary and checks both interrupt outputs on every cycle. A design with a misaligned pulse, a pulse wider than one cycle, or a missing slow pulse at a 1024 boundary is caught in the same sweep. It also drives simultaneous strobes, idle gaps in the tick, and a mid-run reset followed by a high-byte read, which catches a wrong strobe priority, stale holding data and a data output that drifts between reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W_DEF    = 12;
  localparam int unsigned BYTE_W_DEF   = 8;
  localparam int unsigned FAST_LOG_DEF = 7;
  localparam int unsigned SLOW_LOG_DEF = 10;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W    = tmr_pkg::CNT_W_DEF,
  parameter int unsigned FAST_LOG = tmr_pkg::FAST_LOG_DEF,
  parameter int unsigned SLOW_LOG = tmr_pkg::SLOW_LOG_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             irq_fast,
  output logic             irq_slow
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             fast_nxt;
  logic             slow_nxt;

  // Next-state logic: a pulse is due when this tick carries out of the low bits.
  always_comb begin
    cnt_nxt  = cnt;
    fast_nxt = 1'b0;
    slow_nxt = 1'b0;
    if (tick) begin
      cnt_nxt  = cnt + 1'b1;
      fast_nxt = &cnt[FAST_LOG-1:0];
      slow_nxt = &cnt[SLOW_LOG-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      irq_fast <= 1'b0;
      irq_slow <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      irq_fast <= fast_nxt;
      irq_slow <= slow_nxt;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && (&cnt)) |=> (cnt == '0)); // R2
  AST_FAST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) irq_fast |-> (cnt[FAST_LOG-1:0] == '0)); // R6
  AST_FAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_fast |=> !irq_fast); // R6
  AST_SLOW_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) irq_slow |-> (irq_fast && cnt[SLOW_LOG-1:0] == '0)); // R7
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int unsigned CNT_W  = tmr_pkg::CNT_W_DEF,
  parameter int unsigned BYTE_W = tmr_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rdata
);
  localparam int unsigned HI_W  = CNT_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - HI_W;

  logic [HI_W-1:0]   hold;
  logic [HI_W-1:0]   hold_nxt;
  logic [BYTE_W-1:0] rdata_nxt;

  // Low-byte read wins over a simultaneous high-byte read.
  always_comb begin
    hold_nxt  = hold;
    rdata_nxt = rdata;
    if (rd_lo) begin
      hold_nxt  = cnt[CNT_W-1:BYTE_W];
      rdata_nxt = cnt[BYTE_W-1:0];
    end else if (rd_hi) begin
      rdata_nxt = {{PAD_W{1'b0}}, hold};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      rdata <= '0;
    end else begin
      hold  <= hold_nxt;
      rdata <= rdata_nxt;
    end
  end

  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) rd_lo |=> (rdata == $past(cnt[BYTE_W-1:0]))); // R3
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !rd_lo |=> $stable(hold)); // R4
  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_hi && !rd_lo) |=> (rdata[BYTE_W-1:HI_W] == '0)); // R5
  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (!rd_lo && !rd_hi) |=> $stable(rdata)); // R10
endmodule

// File: rtl/tmr12_snapshot.sv
module tmr12_snapshot #(
  parameter int unsigned CNT_W    = tmr_pkg::CNT_W_DEF,
  parameter int unsigned BYTE_W   = tmr_pkg::BYTE_W_DEF,
  parameter int unsigned FAST_LOG = tmr_pkg::FAST_LOG_DEF,
  parameter int unsigned SLOW_LOG = tmr_pkg::SLOW_LOG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_fast,
  output logic              irq_slow
);
  logic             rst_meta;
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;

  // Reset asserts at once, releases after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tmr_count #(
    .CNT_W(CNT_W), .FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)
  ) u_count (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .cnt(cnt), .irq_fast(irq_fast), .irq_slow(irq_slow)
  );

  tmr_snap #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_snap (
    .clk(clk), .rst_n(rst_sync_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .cnt(cnt), .rdata(rdata)
  );

  AST_IRQ_IDLE_RST: assert property (@(posedge clk) !rst_sync_n |-> (!irq_fast && !irq_slow && rdata == '0)); // R8
endmodule

// File: tb/tmr12_snapshot_tb_top.sv
module tmr12_snapshot_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, rd_lo, rd_hi;
  logic [7:0] rdata;
  logic       irq_fast, irq_slow;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [11:0] m_cnt;
  logic [3:0]  m_hold;
  logic [7:0]  m_rd;

  always #(CLK_P/2) clk = ~clk;

  tmr12_snapshot dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rdata(rdata), .irq_fast(irq_fast), .irq_slow(irq_slow)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, sample 1 time unit after the posedge.
  task automatic step(input logic t, input logic lo, input logic hi, input string tag);
    logic ef, es;
    string rtag;
    @(negedge clk);
    tick = t; rd_lo = lo; rd_hi = hi;
    @(posedge clk);
    #1;
    ef = t && (m_cnt[6:0] == 7'h7F);
    es = t && (m_cnt[9:0] == 10'h3FF);
    if (lo) begin
      m_rd   = m_cnt[7:0];
      m_hold = m_cnt[11:8];
    end else if (hi) begin
      m_rd = {4'h0, m_hold};
    end
    if (t) m_cnt = m_cnt + 12'd1;
    rtag = (lo || hi) ? tag : "R10";
    check(rtag, rdata, m_rd);
    check("R6", {7'd0, irq_fast}, {7'd0, ef});
    check("R7", {7'd0, irq_slow}, {7'd0, es});
  endtask

  task automatic reset_seq();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
    #1;
    m_cnt = '0; m_hold = '0; m_rd = '0;
    check("R8", rdata, 8'h00);
    check("R8", {6'd0, irq_fast, irq_slow}, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0, "R8");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
    m_cnt = '0; m_hold = '0; m_rd = '0;
    reset_seq();

    // R8: first high read after reset returns zero
    step(1'b0, 1'b0, 1'b1, "R8");

    // R1: irregular tick pattern, then a coherent read
    for (int i = 0; i < 300; i++) step(i % 3 != 0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b1, "R1");

    // R3 R4 R5: full sweep past a wrap, low reads on tick edges, high reads later
    for (int i = 0; i < 4300; i++) begin
      if (i % 37 == 0)      step(1'b1, 1'b1, 1'b0, "R3");
      else if (i % 37 == 9) step(1'b1, 1'b0, 1'b1, "R5");
      else if (i % 37 == 20) step(1'b0, 1'b0, 1'b1, "R4");
      else                  step(1'b1, 1'b0, 1'b0, "R10");
    end

    // R2: read across the top boundary
    while (m_cnt != 12'hFFF) step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, 1'b0, "R2");
    check("R2", {4'h0, m_cnt[11:8]}, 8'h00);

    // R9: both strobes together
    for (int i = 0; i < 700; i++) step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b1, "R9");

    // R8: mid-run reset clears count and holding register
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    reset_seq();
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule